// File: doc/BRIEF.md
# Translation-Miss Register Updater

This block computes, in one registered step, the coprocessor register values that follow an address-translation miss. When the core raises a miss strobe, the block captures four things: the faulting virtual address, whether the access was a load or a store, the program counter of the faulting instruction, and the interrupt-enable and exception-level status bits. On the next clock edge it presents the new fault-address, page-context, entry-high, cause and exception-PC values, together with the redirected fetch address.

The surrounding control register file supplies the current context and entry-high contents. The block merges the virtual page number into them and leaves the page-table base field, the low context bits and the address-space identifier untouched. A one-cycle done pulse marks the redirect. Write-enable pulses tell the register file when to set the exception-level bit and when to store the exception PC. The outputs hold their last values between misses. Looking up the translation and walking the page table belong to other blocks.

Top module: `tlbm_ctx_updater`

## Requirements
- R1: In the cycle after a miss strobe, `badvaddr` equals the full faulting address captured with the strobe.
- R2: In that cycle, `context_o` bits [22:4] equal faulting-address bits [31:13]; bits [31:23] and [3:0] equal those of `ctx_cur` captured with the strobe.
- R3: In that cycle, `entryhi_o` bits [31:13] equal faulting-address bits [31:13] and bits [12:0] equal `ehi_cur` bits [12:0] captured with the strobe.
- R4: `cause_o` carries the exception code in bits [6:2] and zero in all other bits. The code is 2 for a load miss (`miss_store`=0, value 0x08) and 3 for a store miss (value 0x0C).
- R5: When `st_exl` is 0 at the strobe, `epc_we` pulses and `epc_o` becomes the captured PC minus 4. When `st_exl` is 1, `epc_we` stays low and `epc_o` keeps its previous value.
- R6: `redirect_pc` becomes 0x80000000 when `st_ie` is 0 at the strobe and 0x80000180 when it is 1.
- R7: `upd_done` and `exl_we` are high exactly in the cycle after each strobe. Without a strobe both are low and all register outputs keep their values.
- R8: While reset is asserted, every output is zero.
- R9: Strobes on consecutive cycles each produce their own update in the cycle after their own strobe. A strobe arriving during a done pulse is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_req | input | 1 | Translation-miss strobe |
| miss_store | input | 1 | 1 for a store miss, 0 for a load miss |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_pc | input | 32 | PC of the faulting instruction stream |
| st_ie | input | 1 | Status interrupt-enable bit |
| st_exl | input | 1 | Status exception-level bit before the miss |
| ctx_cur | input | 32 | Current page-context register |
| ehi_cur | input | 32 | Current entry-high register |
| upd_done | output | 1 | One-cycle pulse with the redirect |
| exl_we | output | 1 | Pulse: set the exception-level bit |
| epc_we | output | 1 | Pulse: write `epc_o` into the exception PC |
| badvaddr | output | 32 | New fault-address value |
| context_o | output | 32 | New page-context value |
| entryhi_o | output | 32 | New entry-high value |
| cause_o | output | 32 | New cause value |
| epc_o | output | 32 | New exception-PC value |
| redirect_pc | output | 32 | Vector address to fetch from |

## Verification
The case most likely to go wrong is a second strobe arriving in the same cycle as the done pulse of the first. The result-register enable and the pulse generation then both act on that edge, and the new capture must neither be dropped nor mixed with the old one. The bench drives runs of back-to-back strobes, then a long random stretch of strobes, exception-level values and status values. A behavioural model advances on every clock and is compared against every output in every cycle. That comparison catches both a missed update and a stale exception PC left over from a suppressed write.

// File: rtl/tlbm_pkg.sv
package tlbm_pkg;
  // Exception codes placed in the cause field
  typedef enum logic [4:0] {
    EXC_REFILL_LD = 5'd2,
    EXC_REFILL_ST = 5'd3
  } tlbm_exc_e;
endpackage

// File: rtl/tlbm_field_merge.sv
module tlbm_field_merge #(
  parameter int AW         = 32,
  parameter int PAGE_SHIFT = 13,
  parameter int CTX_LO     = 4
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] ctx_cur,
  input  logic [AW-1:0] ehi_cur,
  output logic [AW-1:0] ctx_new,
  output logic [AW-1:0] ehi_new
);
  localparam int VPN_W  = AW - PAGE_SHIFT;
  localparam int CTX_HI = CTX_LO + VPN_W - 1;

  // Page-number slot of the context is overwritten; base and low bits survive.
  always_comb begin
    ctx_new                = ctx_cur;
    ctx_new[CTX_HI:CTX_LO] = vaddr[AW-1:PAGE_SHIFT];
  end

  // Upper entry-high gets the page number; address-space id is preserved.
  assign ehi_new = {vaddr[AW-1:PAGE_SHIFT], ehi_cur[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/tlbm_vector_sel.sv
module tlbm_vector_sel
  import tlbm_pkg::*;
#(
  parameter int          AW       = 32,
  parameter int          CODE_LSB = 2,
  parameter logic [31:0] VEC_BASE = 32'h8000_0000,
  parameter logic [31:0] GEN_OFS  = 32'h0000_0180,
  parameter int          PC_STEP  = 4
) (
  input  logic          is_store,
  input  logic          ie,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] cause_new,
  output logic [AW-1:0] epc_new,
  output logic [AW-1:0] vec_new
);
  localparam int CODE_W = 5;
  tlbm_exc_e code;

  always_comb begin
    code      = is_store ? EXC_REFILL_ST : EXC_REFILL_LD;
    cause_new = '0;
    cause_new[CODE_LSB +: CODE_W] = code;
  end

  assign epc_new = pc - AW'(PC_STEP);
  assign vec_new = ie ? AW'(VEC_BASE + GEN_OFS) : AW'(VEC_BASE);
endmodule

// File: rtl/tlbm_ctx_updater.sv
module tlbm_ctx_updater #(
  parameter int          AW         = 32,
  parameter int          PAGE_SHIFT = 13,
  parameter int          CTX_LO     = 4,
  parameter logic [31:0] VEC_BASE   = 32'h8000_0000,
  parameter logic [31:0] GEN_OFS    = 32'h0000_0180
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_req,
  input  logic          miss_store,
  input  logic [AW-1:0] miss_vaddr,
  input  logic [AW-1:0] miss_pc,
  input  logic          st_ie,
  input  logic          st_exl,
  input  logic [AW-1:0] ctx_cur,
  input  logic [AW-1:0] ehi_cur,
  output logic          upd_done,
  output logic          exl_we,
  output logic          epc_we,
  output logic [AW-1:0] badvaddr,
  output logic [AW-1:0] context_o,
  output logic [AW-1:0] entryhi_o,
  output logic [AW-1:0] cause_o,
  output logic [AW-1:0] epc_o,
  output logic [AW-1:0] redirect_pc
);
  logic [AW-1:0] ctx_d, ehi_d, cause_d, epc_d, vec_d;
  logic          done_d, epc_we_d;

  logic          done_q, epc_we_q;
  logic [AW-1:0] bva_q, ctx_q, ehi_q, cause_q, epc_q, vec_q;

  tlbm_field_merge #(.AW(AW), .PAGE_SHIFT(PAGE_SHIFT), .CTX_LO(CTX_LO)) u_merge (
    .vaddr   (miss_vaddr),
    .ctx_cur (ctx_cur),
    .ehi_cur (ehi_cur),
    .ctx_new (ctx_d),
    .ehi_new (ehi_d)
  );

  tlbm_vector_sel #(.AW(AW), .VEC_BASE(VEC_BASE), .GEN_OFS(GEN_OFS)) u_vec (
    .is_store  (miss_store),
    .ie        (st_ie),
    .pc        (miss_pc),
    .cause_new (cause_d),
    .epc_new   (epc_d),
    .vec_new   (vec_d)
  );

  // Next-state: pulses and enables
  always_comb begin
    done_d   = miss_req;
    epc_we_d = miss_req & ~st_exl;
  end

  // Pulse registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      epc_we_q <= 1'b0;
    end else begin
      done_q   <= done_d;
      epc_we_q <= epc_we_d;
    end
  end

  // Result registers, enabled by the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bva_q   <= '0;
      ctx_q   <= '0;
      ehi_q   <= '0;
      cause_q <= '0;
      vec_q   <= '0;
    end else if (miss_req) begin
      bva_q   <= miss_vaddr;
      ctx_q   <= ctx_d;
      ehi_q   <= ehi_d;
      cause_q <= cause_d;
      vec_q   <= vec_d;
    end
  end

  // Exception PC only when not already at exception level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        epc_q <= '0;
    else if (epc_we_d) epc_q <= epc_d;
  end

  assign upd_done    = done_q;
  assign exl_we      = done_q;
  assign epc_we      = epc_we_q;
  assign badvaddr    = bva_q;
  assign context_o   = ctx_q;
  assign entryhi_o   = ehi_q;
  assign cause_o     = cause_q;
  assign epc_o       = epc_q;
  assign redirect_pc = vec_q;

  assert_done_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |=> upd_done);
  assert_quiet_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req |=> !upd_done && $stable(badvaddr) && $stable(redirect_pc));
  assert_badvaddr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |=> badvaddr == $past(miss_vaddr));
  assert_epc_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && st_exl) |=> !epc_we && $stable(epc_o));
  assert_vec_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && !st_ie) |=> redirect_pc == AW'(VEC_BASE));
  assert_store_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_req && miss_store) |=> cause_o == AW'(32'h0000_000C));
  assert_entryhi_asid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |=> entryhi_o[PAGE_SHIFT-1:0] == $past(ehi_cur[PAGE_SHIFT-1:0]));
endmodule

// File: tb/sim_tlbm_ctx_updater.sv
module sim_tlbm_ctx_updater;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_req = 1'b0, miss_store = 1'b0, st_ie = 1'b0, st_exl = 1'b0;
  logic [31:0] miss_vaddr = '0, miss_pc = '0, ctx_cur = '0, ehi_cur = '0;
  logic        upd_done, exl_we, epc_we;
  logic [31:0] badvaddr, context_o, entryhi_o, cause_o, epc_o, redirect_pc;

  int checks = 0, fails = 0;
  bit wd_hit = 1'b0;

  // model state
  logic        m_done = 0, m_epcwe = 0;
  logic [31:0] m_bva = 0, m_ctx = 0, m_ehi = 0, m_cause = 0, m_epc = 0, m_vec = 0;

  always #4 clk = ~clk;  // 125 MHz

  tlbm_ctx_updater u0 (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_store(miss_store),
    .miss_vaddr(miss_vaddr), .miss_pc(miss_pc), .st_ie(st_ie), .st_exl(st_exl),
    .ctx_cur(ctx_cur), .ehi_cur(ehi_cur), .upd_done(upd_done), .exl_we(exl_we),
    .epc_we(epc_we), .badvaddr(badvaddr), .context_o(context_o),
    .entryhi_o(entryhi_o), .cause_o(cause_o), .epc_o(epc_o), .redirect_pc(redirect_pc)
  );

  // Behavioural reference, advanced on each edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_done = 0; m_epcwe = 0; m_bva = 0; m_ctx = 0; m_ehi = 0;
      m_cause = 0; m_epc = 0; m_vec = 0;
    end else begin
      m_done  = miss_req;
      m_epcwe = miss_req && !st_exl;
      if (miss_req) begin
        m_bva   = miss_vaddr;
        m_ctx   = (ctx_cur & 32'hFF80_000F) | ((miss_vaddr >> 9) & 32'h007F_FFF0);
        m_ehi   = (miss_vaddr & 32'hFFFF_E000) | (ehi_cur & 32'h0000_1FFF);
        m_cause = miss_store ? 32'h0C : 32'h08;
        m_vec   = st_ie ? 32'h8000_0180 : 32'h8000_0000;
        if (!st_exl) m_epc = miss_pc - 32'd4;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all(input string ctx_tag);
    chk({"R1 badvaddr ", ctx_tag}, badvaddr, m_bva);
    chk({"R2 context ", ctx_tag}, context_o, m_ctx);
    chk({"R3 entryhi ", ctx_tag}, entryhi_o, m_ehi);
    chk({"R4 cause ", ctx_tag}, cause_o, m_cause);
    chk({"R5 epc ", ctx_tag}, epc_o, m_epc);
    chk({"R5 epc_we ", ctx_tag}, {31'b0, epc_we}, {31'b0, m_epcwe});
    chk({"R6 redirect ", ctx_tag}, redirect_pc, m_vec);
    chk({"R7 done ", ctx_tag}, {31'b0, upd_done}, {31'b0, m_done});
    chk({"R7 exl_we ", ctx_tag}, {31'b0, exl_we}, {31'b0, m_done});
  endtask

  // drive at negedge after comparing the results of the previous edge
  task automatic step(input logic req, input logic st, input logic [31:0] va,
                      input logic [31:0] pc, input logic ie, input logic exl,
                      input logic [31:0] c, input logic [31:0] e, input string tag);
    @(negedge clk);
    compare_all(tag);
    miss_req = req; miss_store = st; miss_vaddr = va; miss_pc = pc;
    st_ie = ie; st_exl = exl; ctx_cur = c; ehi_cur = e;
  endtask

  initial begin
    #400000;
    wd_hit = 1'b1;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8 reset badvaddr", badvaddr, 32'h0);
    chk("R8 reset redirect", redirect_pc, 32'h0);
    chk("R8 reset done", {31'b0, upd_done}, 32'h0);
    chk("R8 reset epc_we", {31'b0, epc_we}, 32'h0);
    chk("R8 reset epc", epc_o, 32'h0);
    rst_n = 1'b1;
    // load miss, IE=0, EXL=0 (R1-style single updates)
    step(1, 0, 32'hDEAD_BEEF, 32'h0040_1000, 0, 0, 32'hFFFF_FFFF, 32'h0000_1ABC, "load");
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, "idle_a");
    // store miss, IE=1, EXL=0
    step(1, 1, 32'h1234_5678, 32'h8000_2004, 1, 0, 32'h0000_0000, 32'hFFFF_FFFF, "store");
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, "idle_b");
    // EXL already set: EPC must hold (R5)
    step(1, 0, 32'hFFFF_E000, 32'h1111_1111, 1, 1, 32'h5A5A_5A5A, 32'hA5A5_A5A5, "exl_set");
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, "idle_c");
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, "hold_R7");
    // R9 back-to-back strobes
    step(1, 0, 32'h0000_2000, 32'h0000_0004, 0, 0, 32'h0F0F_0F0F, 32'h0000_0001, "b2b_1_R9");
    step(1, 1, 32'hFFFF_FFFF, 32'h0000_0000, 1, 1, 32'hF0F0_F0F0, 32'h0000_1FFF, "b2b_2_R9");
    step(1, 0, 32'h8000_0000, 32'hBFC0_0000, 1, 0, 32'h1234_5678, 32'h8765_4321, "b2b_3_R9");
    step(0, 0, 32'h0, 32'h0, 0, 0, 32'h0, 32'h0, "b2b_end_R9");
    // random stretch
    for (int i = 0; i < 2000 && !wd_hit; i++) begin
      step(1'($urandom_range(0, 1)), 1'($urandom), $urandom, $urandom,
           1'($urandom), 1'($urandom), $urandom, $urandom, "random");
    end
    @(negedge clk);
    compare_all("final");
    if (wd_hit) begin
      checks++; fails++;
      $display("FAIL watchdog R7 actual=timeout expected=finish");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule